// File: doc/BRIEF.md
# Capture Input Conditioning Front End

This block prepares three capture channels for a timer. For each channel it picks a signal source, which is either a pin or an alternate signal from a quadrature encoder, and resynchronizes that source into the system clock domain. It then gates the signal with the channel's enable and cleans it with a digital glitch filter. The filter can be bypassed. The conditioned level of each channel is presented as a status bit.

An edge detector after the filter turns each qualifying transition of the clean level into a strobe that lasts one clock. The edge type is configurable per channel. The strobes feed the counter and hold logic that sits downstream.

All three glitch filters share one sample strobe. A divider produces this strobe from a 3-bit rate code. A new level is accepted only after the same value has been seen on three sample strobes in a row. All configuration inputs are expected to be held steady while the channels are active.

Top module: `capfe_top`

## Requirements
- R1: While reset is asserted, and on the cycle after it, every event strobe and every level bit is 0.
- R2: For each channel, source code 2'b00 selects its pin input and 2'b10 selects its alternate input. Codes 2'b01 and 2'b11 supply a constant low, so toggling either input then produces no event and the level stays 0.
- R3: When a channel's enable bit is 0, that channel emits no event and its level bit settles to 0, whatever its inputs do.
- R4: For each channel, edge code 2'b00 fires on rising transitions of the clean level only, 2'b01 fires on falling transitions only, and 2'b10 or 2'b11 fires on both.
- R5: Each qualifying transition of the clean level gives exactly one event strobe, one clock wide.
- R6: With the filter active, the clean level takes a new value only after three consecutive sample strobes have seen that value. A pulse spanning fewer than three samples is dropped.
- R7: The sample strobe divides the clock by 1, 2, 4, 16, 32 or 64 for rate codes 3'b000 to 3'b101. Codes 3'b110 and 3'b111 also divide by 64.
- R8: With the bypass bit set, the level bit follows the selected, enabled input. It is 0 two clocks after the input rises and 1 on the third clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_in | input | 3 | Asynchronous pin inputs, bit i feeds channel i |
| alt_in | input | 3 | Asynchronous encoder-derived inputs, bit i feeds channel i |
| src_sel | input | 6 | Source code per channel, channel i at bits [2i+1:2i] |
| ch_en | input | 3 | Channel enables, bit i for channel i |
| flt_rate | input | 3 | Glitch filter sample rate code |
| flt_bypass | input | 1 | 1 bypasses the glitch filter on all channels |
| edge_mode | input | 6 | Edge code per channel, channel i at bits [2i+1:2i] |
| cap_evt | output | 3 | One-clock event strobes |
| cap_level | output | 3 | Clean level of each channel |

## Verification
The assertions check the following on every clock:
- every strobe coincides with a change of the level output;
- a rising-only channel fires only when the level is high, and a falling-only channel only when it is low;
- a disabled channel stays quiet;
- both outputs are cleared after reset.

Some behaviours can only be shown by the bench scenarios, because they depend on timing and stimulus history rather than on any single cycle:
- source selection, including the reserved codes;
- rejection of short pulses at different sample rates;
- the mapping of the out-of-range rate codes;
- the exact three-clock latency in bypass.

// File: rtl/capfe_pkg.sv
// Package: shared encodings and the sample-rate table for the capture front end.
// Assumes: the rate table is small and fixed; callers pass 3-bit codes.
package capfe_pkg;

    // Source choice per channel; the two reserved codes feed a constant low.
    typedef enum logic [1:0] {
        SRC_PIN   = 2'b00,
        SRC_RSV_A = 2'b01,
        SRC_ALT   = 2'b10,
        SRC_RSV_B = 2'b11
    } src_e;

    // Edge qualification per channel; both upper codes mean any edge.
    typedef enum logic [1:0] {
        EDGE_RISE  = 2'b00,
        EDGE_FALL  = 2'b01,
        EDGE_BOTH0 = 2'b10,
        EDGE_BOTH1 = 2'b11
    } edge_e;

    localparam int RATE_W  = 3;
    localparam int RATIO_W = 7;

    // Clock divide ratio for a filter sample-rate code.
    function automatic logic [RATIO_W-1:0] rate_ratio(input logic [RATE_W-1:0] code);
        logic [RATIO_W-1:0] r;
        case (code)
            3'd0:    r = 7'd1;
            3'd1:    r = 7'd2;
            3'd2:    r = 7'd4;
            3'd3:    r = 7'd16;
            3'd4:    r = 7'd32;
            default: r = 7'd64;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/capfe_sync.sv
// Module: two-flop synchronizer for a vector of asynchronous inputs.
// Assumes: each bit is independent; no multi-bit coherency is needed.
module capfe_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1;

    // Two register stages to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            d_sync <= '0;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end
endmodule

// File: rtl/capfe_tick_gen.sv
// Module: produces the shared glitch-filter sample strobe from a rate code.
// Assumes: the rate code is static during use; if it shrinks mid-count the
// counter wraps at the next cycle because of the >= compare.
module capfe_tick_gen
    import capfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int CNT_W = RATIO_W - 1;

    logic [CNT_W-1:0]   cnt;
    logic [RATIO_W-1:0] limit;

    // Terminal count is ratio minus one; ratio 1 gives a strobe every cycle.
    always_comb begin
        limit = rate_ratio(rate) - 7'd1;
        tick  = ({1'b0, cnt} >= limit);
    end

    // Free-running divider counter, restarted at each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/capfe_glitch_filter.sv
// Module: single-bit three-sample majority-free glitch filter with bypass.
// Assumes: tick is a one-cycle strobe; in bypass the output tracks din with
// one register of delay.
module capfe_glitch_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic bypass,
    input  logic din,
    output logic level
);
    logic [1:0] hist;   // hist[0] previous sample, hist[1] the one before

    // Sample history shifted on every strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    hist <= '0;
        else if (tick) hist <= {hist[0], din};
    end

    // Accept a new value after three equal samples, or follow din in bypass.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level <= 1'b0;
        else if (bypass)
            level <= din;
        else if (tick && (din == hist[0]) && (din == hist[1]))
            level <= din;
    end
endmodule

// File: rtl/capfe_edge_det.sv
// Module: qualifies transitions of a clean level and emits a one-cycle strobe.
// Assumes: level is a registered signal, so prev lags it by exactly one cycle.
module capfe_edge_det
    import capfe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level,
    input  logic       enable,
    input  logic [1:0] mode,
    output logic       evt
);
    logic prev;
    logic rise;
    logic fall;

    // Track the level one cycle back.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= level;
    end

    // Pick the qualifying transition for the configured mode.
    always_comb begin
        rise = level & ~prev;
        fall = ~level & prev;
        case (edge_e'(mode))
            EDGE_RISE: evt = enable & rise;
            EDGE_FALL: evt = enable & fall;
            default:   evt = enable & (rise | fall);
        endcase
    end
endmodule

// File: rtl/capfe_top.sv
// Module: capture input front end. Synchronizes the pin and alternate inputs,
// picks a source per channel, gates it with the channel enable, filters it and
// emits edge events and clean levels.
// Assumes: configuration is quasi-static; rst_n is synchronous and active low.
module capfe_top
    import capfe_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    pin_in,
    input  logic [NCH-1:0]    alt_in,
    input  logic [2*NCH-1:0]  src_sel,
    input  logic [NCH-1:0]    ch_en,
    input  logic [RATE_W-1:0] flt_rate,
    input  logic              flt_bypass,
    input  logic [2*NCH-1:0]  edge_mode,
    output logic [NCH-1:0]    cap_evt,
    output logic [NCH-1:0]    cap_level
);
    localparam int SYNC_W = 2 * NCH;

    logic [SYNC_W-1:0] raw_sync;
    logic [NCH-1:0]    pin_s;
    logic [NCH-1:0]    alt_s;
    logic [NCH-1:0]    chan_sel;
    logic [NCH-1:0]    chan_gated;
    logic              sample_tick;

    capfe_sync #(.W(SYNC_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({alt_in, pin_in}),
        .d_sync  (raw_sync)
    );

    assign pin_s = raw_sync[NCH-1:0];
    assign alt_s = raw_sync[SYNC_W-1:NCH];

    capfe_tick_gen u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .rate  (flt_rate),
        .tick  (sample_tick)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // Source mux with reserved codes tied low, then enable gating.
        always_comb begin
            case (src_e'(src_sel[2*i +: 2]))
                SRC_PIN: chan_sel[i] = pin_s[i];
                SRC_ALT: chan_sel[i] = alt_s[i];
                default: chan_sel[i] = 1'b0;
            endcase
            chan_gated[i] = chan_sel[i] & ch_en[i];
        end

        capfe_glitch_filter u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (sample_tick),
            .bypass (flt_bypass),
            .din    (chan_gated[i]),
            .level  (cap_level[i])
        );

        capfe_edge_det u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .level  (cap_level[i]),
            .enable (ch_en[i]),
            .mode   (edge_mode[2*i +: 2]),
            .evt    (cap_evt[i])
        );
    end
endmodule

// File: rtl/capfe_checker.sv
// Module: cycle-level properties of the capture front end, bound to capfe_top.
// Assumes: observes ports only.
module capfe_checker #(
    parameter int NCH = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCH-1:0]   ch_en,
    input logic [2*NCH-1:0] edge_mode,
    input logic [NCH-1:0]   cap_evt,
    input logic [NCH-1:0]   cap_level
);
    // R1: outputs are clear on the cycle after a reset edge.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (cap_evt == '0) && (cap_level == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R5: a strobe only accompanies a change of the clean level.
        assert_evt_on_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
            cap_evt[i] |-> (cap_level[i] != $past(cap_level[i])));

        // R4: rising-only mode fires only with the level high.
        assert_rise_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_evt[i] && edge_mode[2*i +: 2] == 2'b00) |-> cap_level[i]);

        // R4: falling-only mode fires only with the level low.
        assert_fall_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_evt[i] && edge_mode[2*i +: 2] == 2'b01) |-> !cap_level[i]);

        // R3: a disabled channel never fires.
        assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en[i] |-> !cap_evt[i]);
    end
endmodule

bind capfe_top capfe_checker #(.NCH(NCH)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_en     (ch_en),
    .edge_mode (edge_mode),
    .cap_evt   (cap_evt),
    .cap_level (cap_level)
);

// File: tb/capfe_top_tb.sv
// Bench: directed scenarios for capfe_top, one task per scenario.
module capfe_top_tb;
    localparam int NCH = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NCH-1:0]   pin_in;
    logic [NCH-1:0]   alt_in;
    logic [2*NCH-1:0] src_sel;
    logic [NCH-1:0]   ch_en;
    logic [2:0]       flt_rate;
    logic             flt_bypass;
    logic [2*NCH-1:0] edge_mode;
    logic [NCH-1:0]   cap_evt;
    logic [NCH-1:0]   cap_level;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Event monitors: running totals and back-to-back strobe count.
    int evt_tot [NCH];
    int evt_dbl [NCH];
    logic [NCH-1:0] evt_last = '0;

    always #2 clk = ~clk;   // 250 MHz

    capfe_top #(.NCH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .alt_in(alt_in),
        .src_sel(src_sel), .ch_en(ch_en), .flt_rate(flt_rate),
        .flt_bypass(flt_bypass), .edge_mode(edge_mode),
        .cap_evt(cap_evt), .cap_level(cap_level)
    );

    initial begin
        for (int i = 0; i < NCH; i++) begin
            evt_tot[i] = 0;
            evt_dbl[i] = 0;
        end
    end

    always @(negedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (cap_evt[i] === 1'b1) evt_tot[i] = evt_tot[i] + 1;
            if (cap_evt[i] === 1'b1 && evt_last[i] === 1'b1) evt_dbl[i] = evt_dbl[i] + 1;
        end
        evt_last = cap_evt;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic defaults();
        pin_in = '0; alt_in = '0; src_sel = '0; ch_en = '1;
        flt_rate = 3'd0; flt_bypass = 1'b1; edge_mode = '0;
    endtask

    // Pulse one pin high for w cycles, wait settle, return events seen on ch.
    task automatic pulse_pin(input int ch, input int w, input int settle, output int n);
        int base;
        base = evt_tot[ch];
        pin_in[ch] = 1'b1;
        idle(w);
        pin_in[ch] = 1'b0;
        idle(settle);
        n = evt_tot[ch] - base;
    endtask

    task automatic t_reset();
        defaults();
        rst_n = 1'b0;
        pin_in = '1;
        idle(4);
        check(cap_evt == '0 && cap_level == '0, "R1 outputs in reset", int'(cap_level), 0);
        pin_in = '0;
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        check(cap_evt == '0 && cap_level == '0, "R1 outputs after reset", int'(cap_evt), 0);
    endtask

    task automatic t_bypass_latency();
        int base;
        defaults();
        idle(5);
        base = evt_tot[0];
        pin_in[0] = 1'b1;
        idle(2);
        check(cap_level[0] == 1'b0, "R8 level still low after two clocks", int'(cap_level[0]), 0);
        idle(1);
        check(cap_level[0] == 1'b1, "R8 level high on third clock", int'(cap_level[0]), 1);
        idle(6);
        check(evt_tot[0] - base == 1, "R5 one strobe for one rise", evt_tot[0] - base, 1);
        check(evt_dbl[0] == 0, "R5 strobe one clock wide", evt_dbl[0], 0);
        base = evt_tot[0];
        pin_in[0] = 1'b0;
        idle(8);
        check(evt_tot[0] - base == 0, "R4 rising mode ignores fall", evt_tot[0] - base, 0);
    endtask

    task automatic t_edge_modes();
        int b1, b2;
        defaults();
        edge_mode = {2'b11, 2'b01, 2'b00};
        idle(5);
        b1 = evt_tot[1];
        b2 = evt_tot[2];
        pin_in[1] = 1'b1; pin_in[2] = 1'b1;
        idle(8);
        check(evt_tot[1] - b1 == 0, "R4 falling mode ignores rise", evt_tot[1] - b1, 0);
        check(evt_tot[2] - b2 == 1, "R4 both mode sees rise", evt_tot[2] - b2, 1);
        pin_in[1] = 1'b0; pin_in[2] = 1'b0;
        idle(8);
        check(evt_tot[1] - b1 == 1, "R4 falling mode sees fall", evt_tot[1] - b1, 1);
        check(evt_tot[2] - b2 == 2, "R4 both mode sees fall", evt_tot[2] - b2, 2);
        edge_mode[5:4] = 2'b10;
        pin_in[2] = 1'b1; idle(6); pin_in[2] = 1'b0; idle(6);
        check(evt_tot[2] - b2 == 4, "R4 code 10 is both edges", evt_tot[2] - b2, 4);
        check(evt_dbl[1] == 0 && evt_dbl[2] == 0, "R5 no double strobes", evt_dbl[2], 0);
    endtask

    task automatic t_sources();
        int b;
        defaults();
        edge_mode = {2'b10, 2'b10, 2'b10};
        src_sel[1:0] = 2'b10;
        idle(5);
        b = evt_tot[0];
        pin_in[0] = 1'b1; idle(6); pin_in[0] = 1'b0; idle(6);
        check(evt_tot[0] - b == 0, "R2 alt select ignores pin", evt_tot[0] - b, 0);
        alt_in[0] = 1'b1; idle(6);
        check(cap_level[0] == 1'b1, "R2 alt select level", int'(cap_level[0]), 1);
        alt_in[0] = 1'b0; idle(6);
        check(evt_tot[0] - b == 2, "R2 alt select events", evt_tot[0] - b, 2);
        src_sel = {2'b00, 2'b11, 2'b01};
        idle(4);
        b = evt_tot[0] + evt_tot[1];
        pin_in = 3'b011; alt_in = 3'b011; idle(6);
        check(cap_level[1:0] == 2'b00, "R2 reserved codes read low", int'(cap_level[1:0]), 0);
        pin_in = '0; alt_in = '0; idle(6);
        check(evt_tot[0] + evt_tot[1] - b == 0, "R2 reserved codes no events",
              evt_tot[0] + evt_tot[1] - b, 0);
    endtask

    task automatic t_enable();
        int b;
        defaults();
        edge_mode[3:2] = 2'b11;
        ch_en[1] = 1'b0;
        idle(5);
        b = evt_tot[1];
        pin_in[1] = 1'b1; idle(8);
        check(cap_level[1] == 1'b0, "R3 disabled level low", int'(cap_level[1]), 0);
        pin_in[1] = 1'b0; idle(8);
        check(evt_tot[1] - b == 0, "R3 disabled no events", evt_tot[1] - b, 0);
    endtask

    task automatic t_filter_fast();
        int n;
        defaults();
        flt_bypass = 1'b0;
        flt_rate = 3'd0;
        idle(10);
        pulse_pin(0, 2, 12, n);
        check(n == 0, "R6 two-sample pulse dropped", n, 0);
        pulse_pin(0, 6, 12, n);
        check(n == 1, "R6 six-sample pulse accepted", n, 1);
    endtask

    task automatic t_filter_rates();
        int n;
        defaults();
        flt_bypass = 1'b0;
        flt_rate = 3'd3;
        idle(80);
        pulse_pin(0, 30, 80, n);
        check(n == 0, "R7 rate 16 drops 30-cycle pulse", n, 0);
        pulse_pin(0, 100, 80, n);
        check(n == 1, "R7 rate 16 keeps 100-cycle pulse", n, 1);
        flt_rate = 3'd5;
        idle(300);
        pulse_pin(0, 120, 300, n);
        check(n == 0, "R7 rate 64 drops 120-cycle pulse", n, 0);
        flt_rate = 3'd7;
        idle(300);
        pulse_pin(0, 120, 300, n);
        check(n == 0, "R7 code 111 acts as 64", n, 0);
        pulse_pin(0, 400, 300, n);
        check(n == 1, "R7 code 111 keeps long pulse", n, 1);
    endtask

    initial begin
        t_reset();
        t_bypass_latency();
        t_edge_modes();
        t_sources();
        t_enable();
        t_filter_fast();
        t_filter_rates();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule